// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

This block lets several interrupt sources share one interrupt request line and one acknowledge line. It is built from one cell per device and a wrapper that strings the cells into a chain. Each cell latches a request from its device and holds it as pending. The pending bits of all cells are ORed onto a single request output. When the processor answers with an acknowledge, the acknowledge enters cell 0 and moves down the chain. The first cell that is ready to be served stops it and places its own fixed vector on the vector output.

Priority comes only from position in the chain: cell 0 wins over cell 1, cell 1 over cell 2, and so on. Ownership is decided by an arm bit in each cell. The arm bit copies the cell's pending state only while that cell's priority input is low. A request that arrives during an acknowledge therefore cannot take the vector away from the cell that already holds it.

A cell's pending request is removed when the acknowledge it owned ends. The vector output carries a valid qualifier. There is no ready input, because the processor reads the vector while it holds the acknowledge high and cannot apply back-pressure. The vector stays stable for as long as the acknowledge stays high.

Top module: `intack_chain`

## Requirements
- R1: `irq` is high exactly when at least one cell holds a pending request. It is low after reset and whenever nothing is pending.
- R2: A one-cycle pulse on `dev_req[i]` sets pending in cell i at that clock edge. `irq` is high from that edge on, and stays high until the request has been served.
- R3: When `intack` is high and no cell is armed, `ack_out` follows `intack`, `vec_valid` is low and `vec_out` is zero. Whenever any cell is armed, `ack_out` is low.
- R4: While `intack` is high, the armed cell with the lowest index drives `vec_valid` high in the same cycle. It places its vector `VEC_BASE + i*VEC_STEP` on `vec_out`; with the default parameters cell i gives 8'h20 + 4*i. Whenever `vec_valid` is low, `vec_out` is zero.
- R5: When several cells are pending, they are served one per acknowledge, in ascending index order.
- R6: A cell that owned the vector clears its pending request at the first clock edge where `intack` is sampled low.
- R7: A request whose cell's priority input is high when the request is latched does not arm that cell until the priority input goes low. The owner of an acknowledge in progress keeps `vec_out` unchanged until `intack` falls.
- R8: If a new request for a cell arrives on the same edge that clears the cell's served request, the cell stays pending and is served at the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | N_CELLS | Request pulses from the devices, one bit per cell |
| intack | input | 1 | Acknowledge from the processor, the priority input of cell 0 |
| irq | output | 1 | Shared request line, OR of all pending bits |
| vec_out | output | VEC_W | Vector of the owning cell, zero when there is no owner |
| vec_valid | output | 1 | High while some cell drives `vec_out` |
| ack_out | output | 1 | Priority output of the last cell |

## Verification
The results fall due at two different times:
- **Same cycle as `intack`:** `vec_out`, `vec_valid` and `ack_out` depend combinationally on `intack` and the arm bits.
- **One edge after the stimulus:**
  - `irq` rises one edge after a `dev_req` pulse.
  - A served request is cleared one edge after `intack` is sampled low.

The bench drives inputs on the falling edge and compares all outputs against a behavioural model 3 ns later, inside the same cycle. Directed checks sample 1 ns after that, so each check lands where both the combinational and the registered results have settled. The model updates its pending, arm and owner state on each rising edge, from the inputs it sampled there.

// File: rtl/intack_chain_pkg.sv
package intack_chain_pkg;

  // Vector assigned to the cell at chain position idx.
  function automatic int unsigned cell_vector(input int unsigned base,
                                              input int unsigned step,
                                              input int unsigned idx);
    return base + step * idx;
  endfunction

endpackage

// File: rtl/intack_cell.sv
module intack_cell #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned VEC_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             pi,
  output logic             po,
  output logic             pend,
  output logic             own,
  output logic [VEC_W-1:0] vec
);

  localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(VEC_VAL);

  logic pend_q;
  logic arm_q;
  logic own_q;
  logic clr;
  logic pend_nxt;

  // The acknowledge this cell owned has ended.
  assign clr      = own_q & ~pi;
  assign pend_nxt = (pend_q & ~clr) | req;

  // Ownership is decided by the arm bit, which is frozen while pi is high.
  assign own  = arm_q & pi;
  assign po   = pi & ~arm_q;
  assign pend = pend_q;
  assign vec  = own ? MY_VEC : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      own_q  <= own;
      if (!pi) begin
        arm_q <= pend_nxt;
      end
    end
  end

endmodule

// File: rtl/intack_vec_merge.sv
module intack_vec_merge #(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [N_CELLS-1:0][VEC_W-1:0] vecs,
  input  logic [N_CELLS-1:0]            owns,
  output logic [VEC_W-1:0]              vec_out,
  output logic                          vec_valid
);

  // Non-owners drive zero, so a plain OR merges the vectors.
  always_comb begin
    vec_out = '0;
    for (int i = 0; i < int'(N_CELLS); i++) begin
      vec_out = vec_out | vecs[i];
    end
  end

  assign vec_valid = |owns;

endmodule

// File: rtl/intack_chain.sv
module intack_chain
  import intack_chain_pkg::*;
#(
  parameter int unsigned N_CELLS  = 4,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 32'h20,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CELLS-1:0] dev_req,
  input  logic               intack,
  output logic               irq,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic               ack_out
);

  localparam int unsigned N_LINKS = N_CELLS + 1;

  logic [N_LINKS-1:0]               link;
  logic [N_CELLS-1:0]               pend_vec;
  logic [N_CELLS-1:0]               own_vec;
  logic [N_CELLS-1:0][VEC_W-1:0]    cell_vecs;

  assign link[0] = intack;

  for (genvar g = 0; g < int'(N_CELLS); g++) begin : g_cell
    intack_cell #(
      .VEC_W  (VEC_W),
      .VEC_VAL(cell_vector(VEC_BASE, VEC_STEP, g))
    ) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (dev_req[g]),
      .pi   (link[g]),
      .po   (link[g+1]),
      .pend (pend_vec[g]),
      .own  (own_vec[g]),
      .vec  (cell_vecs[g])
    );
  end

  intack_vec_merge #(
    .N_CELLS(N_CELLS),
    .VEC_W  (VEC_W)
  ) u_merge (
    .vecs     (cell_vecs),
    .owns     (own_vec),
    .vec_out  (vec_out),
    .vec_valid(vec_valid)
  );

  assign irq     = |pend_vec;
  assign ack_out = link[N_CELLS];

endmodule

// File: rtl/intack_chain_chk.sv
module intack_chain_chk #(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CELLS-1:0] dev_req,
  input logic               intack,
  input logic               irq,
  input logic [VEC_W-1:0]   vec_out,
  input logic               vec_valid,
  input logic               ack_out,
  input logic [N_CELLS-1:0] pend_vec
);

  // R1
  no_vec_without_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> !vec_valid);

  // R2
  req_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_req) |=> irq);

  // R3
  ack_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> (intack && !vec_valid));

  // R4
  vec_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> intack);

  // R4
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_out == '0));

  // R6
  served_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!intack && $past(intack) && $past(vec_valid) && (dev_req == '0))
    |=> ($countones(pend_vec) == $countones($past(pend_vec)) - 1));

  // R7
  owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && intack && $past(vec_valid) && $past(intack)) |-> $stable(vec_out));

endmodule

bind intack_chain intack_chain_chk #(
  .N_CELLS(N_CELLS),
  .VEC_W  (VEC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dev_req  (dev_req),
  .intack   (intack),
  .irq      (irq),
  .vec_out  (vec_out),
  .vec_valid(vec_valid),
  .ack_out  (ack_out),
  .pend_vec (pend_vec)
);

// File: tb/intack_chain_bench.sv
module intack_chain_bench;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic         intack = 1'b0;
  logic         irq;
  logic [7:0]   vec_out;
  logic         vec_valid;
  logic         ack_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // behavioural reference state
  bit pend_m[N];
  bit arm_m[N];
  bit own_m[N];

  always #5 clk = ~clk;

  intack_chain u_intack_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_req  (dev_req),
    .intack   (intack),
    .irq      (irq),
    .vec_out  (vec_out),
    .vec_valid(vec_valid),
    .ack_out  (ack_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic int first_armed();
    for (int i = 0; i < N; i++) if (arm_m[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        pend_m[i] = 0; arm_m[i] = 0; own_m[i] = 0;
      end
    end else begin
      int fa;
      fa = first_armed();
      for (int i = 0; i < N; i++) begin
        bit reach, done_srv, pn;
        reach    = intack && (fa < 0 || i <= fa);
        done_srv = own_m[i] && !intack;
        pn       = (pend_m[i] && !done_srv) || dev_req[i];
        own_m[i] = intack && (i == fa);
        if (!reach) arm_m[i] = pn;
        pend_m[i] = pn;
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      int fa;
      bit e_irq, e_val, e_ack;
      int e_vec;
      fa    = first_armed();
      e_irq = 0;
      for (int i = 0; i < N; i++) e_irq |= pend_m[i];
      e_val = intack && fa >= 0;
      e_vec = e_val ? 32'h20 + 4 * fa : 0;
      e_ack = intack && fa < 0;
      chk(irq == e_irq, "R1 irq", int'(irq), int'(e_irq));
      chk(vec_valid == e_val, "R4 vec_valid", int'(vec_valid), int'(e_val));
      chk(int'(vec_out) == e_vec, "R4 vec_out", int'(vec_out), e_vec);
      chk(ack_out == e_ack, "R3 ack_out", int'(ack_out), int'(e_ack));
    end
  end

  task automatic drive(input logic [N-1:0] r, input logic a);
    @(negedge clk);
    dev_req = r;
    intack  = a;
    #4;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #4;
    chk(irq == 1'b0 && vec_valid == 1'b0, "R1 reset", int'({irq, vec_valid}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: acknowledge with nothing pending passes through
    drive('0, 1'b1);
    chk(ack_out == 1'b1 && vec_valid == 1'b0, "R3 pass-through",
        int'({ack_out, vec_valid}), 2);
    drive('0, 1'b0);

    // R2, R4, R6: single request on cell 2
    drive(4'b0100, 1'b0);
    drive('0, 1'b0);
    chk(irq == 1'b1, "R2 irq set", int'(irq), 1);
    drive('0, 1'b0);
    chk(irq == 1'b1, "R2 irq held", int'(irq), 1);
    drive('0, 1'b1);
    chk(vec_valid && vec_out == 8'h28, "R4 cell2 vector", int'(vec_out), 32'h28);
    chk(ack_out == 1'b0, "R3 blocked", int'(ack_out), 0);
    drive('0, 1'b1);
    drive('0, 1'b0);
    drive('0, 1'b0);
    chk(irq == 1'b0, "R6 cleared", int'(irq), 0);

    // R5: cells 1 and 3 pending, served in index order
    drive(4'b1010, 1'b0);
    drive('0, 1'b0);
    drive('0, 1'b1);
    chk(vec_out == 8'h24, "R5 first cell1", int'(vec_out), 32'h24);
    drive('0, 1'b0);
    drive('0, 1'b0);
    chk(irq == 1'b1, "R5 cell3 still pending", int'(irq), 1);
    drive('0, 1'b1);
    chk(vec_out == 8'h2C, "R5 then cell3", int'(vec_out), 32'h2C);
    drive('0, 1'b0);
    drive('0, 1'b0);
    chk(irq == 1'b0, "R6 all served", int'(irq), 0);

    // R7: higher-priority request during an acknowledge does not steal it
    drive(4'b1000, 1'b0);
    drive('0, 1'b0);
    drive('0, 1'b1);
    drive(4'b0001, 1'b1);
    drive('0, 1'b1);
    chk(vec_out == 8'h2C, "R7 owner kept", int'(vec_out), 32'h2C);
    drive('0, 1'b0);
    drive('0, 1'b1);
    chk(vec_out == 8'h20, "R7 late cell0 served next", int'(vec_out), 32'h20);
    drive('0, 1'b0);
    drive('0, 1'b0);
    chk(irq == 1'b0, "R7 drained", int'(irq), 0);

    // R8: new request on the clearing edge keeps the cell pending
    drive(4'b0100, 1'b0);
    drive('0, 1'b0);
    drive('0, 1'b1);
    drive(4'b0100, 1'b0);
    drive('0, 1'b0);
    chk(irq == 1'b1, "R8 still pending", int'(irq), 1);
    drive('0, 1'b1);
    chk(vec_out == 8'h28, "R8 served again", int'(vec_out), 32'h28);
    drive('0, 1'b0);
    drive('0, 1'b0);
    chk(irq == 1'b0, "R8 drained", int'(irq), 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule